// File: doc/BRIEF.md
# Paged Network Controller Register Bank

This block is the host-side register file of a small Ethernet controller. A host reaches it through a 4-bit byte address with separate write and read strobes. A command register, always found at address 0, carries start, stop, transmit and remote-transfer bits. Its top two bits pick a page, and that page decides which register the other fifteen addresses reach. The bank keeps the receive ring limits, the boundary and current receive pages, and the transmit page and length. It also keeps the remote transfer address and length, a data configuration byte, the six station address bytes and an eight-byte multicast filter mask. All of these are also driven as outputs for the receive, transmit and filtering logic around it.

The block owns the interrupt status and mask registers and drives a level interrupt. Event sources elsewhere in the controller raise status bits through a set vector. Software clears a status bit by writing a one to it. Command writes that start a transmit or a remote transfer produce one-cycle request pulses. When a remote transfer is started with a length of zero, the block signals remote-transfer completion at once and sends no request. The block moves no packet data itself.

Top module: `nic_regbank`

## Requirements
- R1: After synchronous reset, the command register reads 0x01 (stop bit 0 set), interrupt status reads 0x80, the interrupt mask is 0x00 and `irq` is low.
- R2: Address 0 reads and writes the command register on every page. Any other address selects the register whose 6-bit index is {command[7:6], address}. Page 0 is command bits 00 and page 1 is 01.
- R3: A write to page 0 address 7 clears each interrupt status bit written as 1 and leaves the others unchanged. If the same bit is raised by an event in the same cycle, the set wins.
- R4: `irq` is high exactly when interrupt status AND interrupt mask (page 0 address 15) is nonzero, starting the cycle after the write or event that changes either one.
- R5: Each set bit of `evt_set` sets the matching interrupt status bit on the next clock. The status bit map is: 0 receive ok, 1 transmit ok, 2 receive error, 3 transmit error, 4 ring overwrite, 5 counter overflow, 6 remote transfer done, 7 reset done.
- R6: A command write with start (bit 1) and remote read (bit 3) or remote write (bit 4) set behaves in one of two ways. If the remote length is zero, it sets status bit 6 and gives no request. Otherwise it pulses `rdma_req` for one cycle, with `rdma_addr` and `rdma_len` taken from the registers and `rdma_wr` equal to bit 4.
- R7: A command write with start and transmit (bit 2) set pulses `tx_req` for one cycle, with `tx_addr` = transmit page × 256 and `tx_len` = the 16-bit transmit length. The transmit status register (page 0 address 4) becomes 0x01 and status bit 1 is set.
- R8: On page 1, addresses 1–6 hold station address bytes 0–5, address 7 holds the current receive page and addresses 8–15 hold multicast bytes 0–7. All of them read back what was written.
- R9: Page 0 writes work as follows. Address 1 and address 2 set `ring_start` and `ring_stop` to the value × 256. Address 3 sets the boundary, which reads back. Addresses 4/5/6 load the transmit page and length low/high. Addresses 8/9 load the remote address low/high, 10/11 load the remote length low/high, and 14 loads the data configuration.
- R10: A read of any index not listed as readable returns 0x00. Readable indices are the command register, page 0 addresses 3, 4 and 7, and page 1 addresses 1–15.
- R11: Writes on pages 2 and 3 (other than to address 0) change no register.
- R12: `rd_data` is loaded one clock after a cycle with `rd_en` high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| evt_set | input | 8 | Interrupt status set vector from event sources |
| irq | output | 1 | Level interrupt |
| tx_req | output | 1 | Transmit start pulse |
| tx_addr | output | 16 | Transmit buffer byte address |
| tx_len | output | 16 | Transmit length |
| rdma_req | output | 1 | Remote transfer start pulse |
| rdma_wr | output | 1 | Remote transfer direction, 1 = write |
| rdma_addr | output | 16 | Remote transfer address |
| rdma_len | output | 16 | Remote transfer length |
| ring_start | output | 16 | Receive ring start byte address |
| ring_stop | output | 16 | Receive ring stop byte address |
| ring_bnd | output | 8 | Boundary page |
| rx_cur | output | 8 | Current receive page |
| sta_addr | output | 48 | Station address, byte 0 in bits 7:0 |
| mc_mask | output | 64 | Multicast mask, byte 0 in bits 7:0 |
| dcfg | output | 8 | Data configuration byte |

## Verification
A wrong page field in the command register shows up on the very next read. Page 1 station bytes come back as page 0 values or zeros, and writes on pages 2 and 3 corrupt the boundary. A fault in status or mask is visible on `irq` one cycle after the write or event that exposes it. A read-back of address 7 then shows which bit is stuck or was lost to a clear that should have lost to a set. Faults on the request path show up in the cycle after the command write: a missing or doubled pulse, a wrong address or length, or a zero-length remote start that fails to raise bit 6.

// File: rtl/nic_regbank_pkg.sv
package nic_regbank_pkg;

    localparam int BYTE_W = 8;
    localparam int HOST_AW = 4;
    localparam int IDX_W = HOST_AW + 2;

    typedef logic [IDX_W-1:0] reg_idx_t;

    // page 0 indices
    localparam reg_idx_t IX_RING_BEG = 6'h01;
    localparam reg_idx_t IX_RING_END = 6'h02;
    localparam reg_idx_t IX_BND      = 6'h03;
    localparam reg_idx_t IX_TXPG     = 6'h04;
    localparam reg_idx_t IX_TXLEN_L  = 6'h05;
    localparam reg_idx_t IX_TXLEN_H  = 6'h06;
    localparam reg_idx_t IX_STATUS   = 6'h07;
    localparam reg_idx_t IX_RADR_L   = 6'h08;
    localparam reg_idx_t IX_RADR_H   = 6'h09;
    localparam reg_idx_t IX_RLEN_L   = 6'h0a;
    localparam reg_idx_t IX_RLEN_H   = 6'h0b;
    localparam reg_idx_t IX_DCFG     = 6'h0e;
    localparam reg_idx_t IX_MASK     = 6'h0f;
    // page 1 indices
    localparam reg_idx_t IX_STA_BASE = 6'h11;
    localparam reg_idx_t IX_CUR      = 6'h17;
    localparam reg_idx_t IX_MC_BASE  = 6'h18;

    // command bits
    localparam int CB_STOP  = 0;
    localparam int CB_START = 1;
    localparam int CB_TX    = 2;
    localparam int CB_RRD   = 3;
    localparam int CB_RWR   = 4;
    localparam logic [BYTE_W-1:0] CMD_RESET = 8'h01;

    // status bits
    localparam int SB_TX_OK  = 1;
    localparam int SB_RD_DONE = 6;
    localparam logic [BYTE_W-1:0] STATUS_RESET = 8'h80;
    localparam logic [BYTE_W-1:0] TX_STATUS_OK = 8'h01;

    typedef struct packed {
        logic tx_fire;
        logic rdma_fire;
        logic rdma_empty;
    } cmd_evt_t;

    typedef struct packed {
        logic [15:0] ring_beg;
        logic [15:0] ring_end;
        logic [7:0]  bnd;
        logic [7:0]  tx_pg;
        logic [15:0] tx_len;
        logic [15:0] radr;
        logic [15:0] rlen;
        logic [7:0]  dcfg;
        logic [7:0]  tx_stat;
    } pg0_regs_t;

    function automatic reg_idx_t make_idx(input logic [1:0] pg, input logic [HOST_AW-1:0] a);
        return {pg, a};
    endfunction

    function automatic logic [15:0] put_lo(input logic [15:0] cur, input logic [7:0] b);
        return {cur[15:8], b};
    endfunction

    function automatic logic [15:0] put_hi(input logic [15:0] cur, input logic [7:0] b);
        return {b, cur[7:0]};
    endfunction

endpackage

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
    import nic_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cmd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rlen_zero,
    output logic [BYTE_W-1:0] cmd_q,
    output cmd_evt_t          evt,
    output logic              tx_req,
    output logic              rdma_req
);
    logic remote_go;

    always_comb begin
        remote_go      = wdata[CB_START] & (wdata[CB_RRD] | wdata[CB_RWR]);
        evt.tx_fire    = wr_cmd & wdata[CB_START] & wdata[CB_TX];
        evt.rdma_fire  = wr_cmd & remote_go & ~rlen_zero;
        evt.rdma_empty = wr_cmd & remote_go & rlen_zero;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= CMD_RESET;
            tx_req   <= 1'b0;
            rdma_req <= 1'b0;
        end else begin
            if (wr_cmd) cmd_q <= wdata;
            tx_req   <= evt.tx_fire;
            rdma_req <= evt.rdma_fire;
        end
    end
endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
    import nic_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] set_bits,
    input  logic              clr_wr,
    input  logic              mask_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] status_q,
    output logic [BYTE_W-1:0] mask_q,
    output logic              irq
);
    logic [BYTE_W-1:0] clr_bits;

    always_comb begin
        clr_bits = clr_wr ? wdata : '0;
        irq      = |(status_q & mask_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= STATUS_RESET;
            mask_q   <= '0;
        end else begin
            status_q <= (status_q & ~clr_bits) | set_bits;
            if (mask_wr) mask_q <= wdata;
        end
    end
endmodule

// File: rtl/nic_page_regs.sv
module nic_page_regs
    import nic_regbank_pkg::*;
#(
    parameter int STA_N = 6,
    parameter int MC_N  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr,
    input  reg_idx_t                idx,
    input  logic [BYTE_W-1:0]       wdata,
    input  logic                    tx_done,
    output pg0_regs_t               p0,
    output logic [BYTE_W-1:0]       cur_q,
    output logic [STA_N*BYTE_W-1:0] sta_flat,
    output logic [MC_N*BYTE_W-1:0]  mc_flat,
    output logic [BYTE_W-1:0]       rd_val
);
    logic [BYTE_W-1:0] sta_q [STA_N];
    logic [BYTE_W-1:0] mc_q  [MC_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            p0    <= '0;
            cur_q <= '0;
        end else begin
            if (wr) begin
                case (idx)
                    IX_RING_BEG: p0.ring_beg <= {wdata, 8'h00};
                    IX_RING_END: p0.ring_end <= {wdata, 8'h00};
                    IX_BND:      p0.bnd      <= wdata;
                    IX_TXPG:     p0.tx_pg    <= wdata;
                    IX_TXLEN_L:  p0.tx_len   <= put_lo(p0.tx_len, wdata);
                    IX_TXLEN_H:  p0.tx_len   <= put_hi(p0.tx_len, wdata);
                    IX_RADR_L:   p0.radr     <= put_lo(p0.radr, wdata);
                    IX_RADR_H:   p0.radr     <= put_hi(p0.radr, wdata);
                    IX_RLEN_L:   p0.rlen     <= put_lo(p0.rlen, wdata);
                    IX_RLEN_H:   p0.rlen     <= put_hi(p0.rlen, wdata);
                    IX_DCFG:     p0.dcfg     <= wdata;
                    IX_CUR:      cur_q       <= wdata;
                    default: ;
                endcase
            end
            if (tx_done) p0.tx_stat <= TX_STATUS_OK;
        end
    end

    for (genvar g = 0; g < STA_N; g++) begin : g_sta
        always_ff @(posedge clk) begin
            if (rst) sta_q[g] <= '0;
            else if (wr && idx == IX_STA_BASE + reg_idx_t'(g)) sta_q[g] <= wdata;
        end
        assign sta_flat[g*BYTE_W +: BYTE_W] = sta_q[g];
    end

    for (genvar g = 0; g < MC_N; g++) begin : g_mc
        always_ff @(posedge clk) begin
            if (rst) mc_q[g] <= '0;
            else if (wr && idx == IX_MC_BASE + reg_idx_t'(g)) mc_q[g] <= wdata;
        end
        assign mc_flat[g*BYTE_W +: BYTE_W] = mc_q[g];
    end

    always_comb begin
        rd_val = '0;
        case (idx)
            IX_BND:  rd_val = p0.bnd;
            IX_TXPG: rd_val = p0.tx_stat;
            IX_CUR:  rd_val = cur_q;
            default: ;
        endcase
        for (int k = 0; k < STA_N; k++)
            if (idx == IX_STA_BASE + reg_idx_t'(k)) rd_val = sta_q[k];
        for (int k = 0; k < MC_N; k++)
            if (idx == IX_MC_BASE + reg_idx_t'(k)) rd_val = mc_q[k];
    end
endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
    import nic_regbank_pkg::*;
#(
    parameter int STA_N = 6,
    parameter int MC_N  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [HOST_AW-1:0]      addr,
    input  logic                    wr_en,
    input  logic [BYTE_W-1:0]       wr_data,
    input  logic                    rd_en,
    output logic [BYTE_W-1:0]       rd_data,
    input  logic [BYTE_W-1:0]       evt_set,
    output logic                    irq,
    output logic                    tx_req,
    output logic [15:0]             tx_addr,
    output logic [15:0]             tx_len,
    output logic                    rdma_req,
    output logic                    rdma_wr,
    output logic [15:0]             rdma_addr,
    output logic [15:0]             rdma_len,
    output logic [15:0]             ring_start,
    output logic [15:0]             ring_stop,
    output logic [BYTE_W-1:0]       ring_bnd,
    output logic [BYTE_W-1:0]       rx_cur,
    output logic [STA_N*BYTE_W-1:0] sta_addr,
    output logic [MC_N*BYTE_W-1:0]  mc_mask,
    output logic [BYTE_W-1:0]       dcfg
);
    logic [BYTE_W-1:0] cmd_q;
    logic [BYTE_W-1:0] isr_q;
    logic [BYTE_W-1:0] imr_q;
    logic [BYTE_W-1:0] set_vec;
    logic [BYTE_W-1:0] pg_rd;
    logic [BYTE_W-1:0] rd_next;
    logic [15:0]       rcnt_q;
    logic              at_cmd;
    logic              wr_cmd;
    logic              wr_reg;
    reg_idx_t          idx;
    cmd_evt_t          evt;
    pg0_regs_t         p0;

    always_comb begin
        at_cmd = (addr == '0);
        idx    = make_idx(cmd_q[7:6], addr);
        wr_cmd = wr_en & at_cmd;
        wr_reg = wr_en & ~at_cmd;
        rcnt_q = p0.rlen;
        set_vec = evt_set;
        set_vec[SB_TX_OK]   = evt_set[SB_TX_OK] | evt.tx_fire;
        set_vec[SB_RD_DONE] = evt_set[SB_RD_DONE] | evt.rdma_empty;
    end

    nic_cmd_ctrl u_cmd (
        .clk       (clk),
        .rst       (rst),
        .wr_cmd    (wr_cmd),
        .wdata     (wr_data),
        .rlen_zero (rcnt_q == 16'd0),
        .cmd_q     (cmd_q),
        .evt       (evt),
        .tx_req    (tx_req),
        .rdma_req  (rdma_req)
    );

    nic_irq_unit u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_bits (set_vec),
        .clr_wr   (wr_reg && idx == IX_STATUS),
        .mask_wr  (wr_reg && idx == IX_MASK),
        .wdata    (wr_data),
        .status_q (isr_q),
        .mask_q   (imr_q),
        .irq      (irq)
    );

    nic_page_regs #(.STA_N(STA_N), .MC_N(MC_N)) u_pages (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_reg),
        .idx      (idx),
        .wdata    (wr_data),
        .tx_done  (evt.tx_fire),
        .p0       (p0),
        .cur_q    (rx_cur),
        .sta_flat (sta_addr),
        .mc_flat  (mc_mask),
        .rd_val   (pg_rd)
    );

    always_comb begin
        if (at_cmd)                rd_next = cmd_q;
        else if (idx == IX_STATUS) rd_next = isr_q;
        else                       rd_next = pg_rd;
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    assign tx_addr    = {p0.tx_pg, 8'h00};
    assign tx_len     = p0.tx_len;
    assign rdma_wr    = cmd_q[CB_RWR];
    assign rdma_addr  = p0.radr;
    assign rdma_len   = p0.rlen;
    assign ring_start = p0.ring_beg;
    assign ring_stop  = p0.ring_end;
    assign ring_bnd   = p0.bnd;
    assign dcfg       = p0.dcfg;
endmodule

// File: rtl/nic_regbank_chk.sv
module nic_regbank_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  addr,
    input logic        wr_en,
    input logic [7:0]  wr_data,
    input logic [7:0]  evt_set,
    input logic [7:0]  cmd,
    input logic [7:0]  isr,
    input logic [15:0] rcnt,
    input logic        tx_req,
    input logic        rdma_req,
    input logic [15:0] rdma_len
);
    // R3
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 4'd7 && cmd[7:6] == 2'b00 && evt_set == 8'h00)
        |=> ((isr & $past(wr_data)) == 8'h00));

    // R5
    a_r5_event_sets: assert property (@(posedge clk) disable iff (rst)
        (evt_set != 8'h00) |=> ((isr & $past(evt_set)) == $past(evt_set)));

    // R6
    a_r6_zero_len_done: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 4'd0 && wr_data[1] && (wr_data[3] || wr_data[4]) && rcnt == 16'd0)
        |=> isr[6]);

    // R6
    a_r6_req_nonzero: assert property (@(posedge clk) disable iff (rst)
        rdma_req |-> (rdma_len != 16'd0));

    // R7
    a_r7_tx_pulse: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 4'd0 && wr_data[1] && wr_data[2]) |=> (tx_req && isr[1]));
endmodule

bind nic_regbank nic_regbank_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .evt_set  (evt_set),
    .cmd      (cmd_q),
    .isr      (isr_q),
    .rcnt     (rcnt_q),
    .tx_req   (tx_req),
    .rdma_req (rdma_req),
    .rdma_len (rdma_len)
);

// File: tb/test_nic_regbank.sv
module test_nic_regbank;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [7:0]  evt_set = '0;
    logic        irq, tx_req, rdma_req, rdma_wr;
    logic [15:0] tx_addr, tx_len, rdma_addr, rdma_len, ring_start, ring_stop;
    logic [7:0]  ring_bnd, rx_cur, dcfg;
    logic [47:0] sta_addr;
    logic [63:0] mc_mask;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_flag = 1'b0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_regbank i_nic_regbank (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .evt_set(evt_set), .irq(irq),
        .tx_req(tx_req), .tx_addr(tx_addr), .tx_len(tx_len),
        .rdma_req(rdma_req), .rdma_wr(rdma_wr), .rdma_addr(rdma_addr),
        .rdma_len(rdma_len), .ring_start(ring_start), .ring_stop(ring_stop),
        .ring_bnd(ring_bnd), .rx_cur(rx_cur), .sta_addr(sta_addr),
        .mc_mask(mc_mask), .dcfg(dcfg)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: pushes the expected byte, monitor compares when it appears
    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    always @(posedge clk) rd_flag <= rd_en;

    always @(negedge clk) begin
        if (rd_flag) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 unexpected read", 32'(rd_data), 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data === e, t, 32'(rd_data), 32'(e));
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(irq === 1'b0, "R1 irq after reset", 32'(irq), 0);
        rd(4'd0, 8'h01, "R1 command reset");
        rd(4'd7, 8'h80, "R1 status reset");

        // R4 mask exposes reset bit
        wr(4'hf, 8'h80);
        check(irq === 1'b1, "R4 irq with mask", 32'(irq), 1);
        // R3 clear
        wr(4'd7, 8'h80);
        check(irq === 1'b0, "R3 R4 irq after clear", 32'(irq), 0);
        rd(4'd7, 8'h00, "R3 status cleared");

        // R5 events
        evt_set = 8'h05;
        @(negedge clk);
        evt_set = 8'h00;
        rd(4'd7, 8'h05, "R5 event bits");
        check(irq === 1'b0, "R4 masked events", 32'(irq), 0);
        wr(4'hf, 8'h04);
        check(irq === 1'b1, "R4 irq bit2", 32'(irq), 1);
        wr(4'd7, 8'h01);
        rd(4'd7, 8'h04, "R3 partial clear");
        // R3 set wins over clear
        addr = 4'd7; wr_data = 8'h04; wr_en = 1'b1; evt_set = 8'h04;
        @(negedge clk);
        wr_en = 1'b0; evt_set = 8'h00;
        rd(4'd7, 8'h04, "R3 set wins");
        wr(4'd7, 8'hff);
        check(irq === 1'b0, "R4 irq all cleared", 32'(irq), 0);

        // R9 page 0 configuration
        wr(4'd1, 8'h40);
        wr(4'd2, 8'h80);
        wr(4'd3, 8'h4c);
        wr(4'he, 8'h49);
        check(ring_start === 16'h4000, "R9 ring start", 32'(ring_start), 32'h4000);
        check(ring_stop === 16'h8000, "R9 ring stop", 32'(ring_stop), 32'h8000);
        check(dcfg === 8'h49, "R9 dcfg", 32'(dcfg), 32'h49);
        rd(4'd3, 8'h4c, "R9 boundary");
        rd(4'd1, 8'h00, "R10 start page unreadable");

        // R7 transmit
        wr(4'd4, 8'h45);
        wr(4'd5, 8'h3c);
        wr(4'd6, 8'h01);
        wr(4'd0, 8'h26);
        check(tx_req === 1'b1, "R7 tx pulse", 32'(tx_req), 1);
        check(tx_addr === 16'h4500, "R7 tx addr", 32'(tx_addr), 32'h4500);
        check(tx_len === 16'h013c, "R7 tx len", 32'(tx_len), 32'h013c);
        @(negedge clk);
        check(tx_req === 1'b0, "R7 single pulse", 32'(tx_req), 0);
        rd(4'd4, 8'h01, "R7 tx status");
        rd(4'd7, 8'h02, "R7 status bit1");
        wr(4'd7, 8'hff);

        // R6 zero-length remote start
        wr(4'd0, 8'h0a);
        check(rdma_req === 1'b0, "R6 no request at zero", 32'(rdma_req), 0);
        rd(4'd7, 8'h40, "R6 done at zero length");
        wr(4'd7, 8'hff);
        wr(4'd8, 8'h10);
        wr(4'd9, 8'h20);
        wr(4'ha, 8'h08);
        wr(4'hb, 8'h00);
        wr(4'd0, 8'h12);
        check(rdma_req === 1'b1, "R6 request pulse", 32'(rdma_req), 1);
        check(rdma_addr === 16'h2010, "R6 remote addr", 32'(rdma_addr), 32'h2010);
        check(rdma_len === 16'h0008, "R6 remote len", 32'(rdma_len), 32'h8);
        check(rdma_wr === 1'b1, "R6 remote dir", 32'(rdma_wr), 1);
        rd(4'd7, 8'h00, "R6 no done when nonzero");

        // R2 / R8 page 1
        wr(4'd0, 8'h42);
        rd(4'd0, 8'h42, "R2 command on page 1");
        for (int i = 1; i < 16; i++) wr(4'(i), 8'(8'h30 + i));
        for (int i = 1; i < 16; i++) rd(4'(i), 8'(8'h30 + i), "R8 page1 readback");
        check(sta_addr[7:0] === 8'h31 && sta_addr[47:40] === 8'h36, "R8 station out",
              32'(sta_addr[47:16]), 32'h3635_3433);
        check(rx_cur === 8'h37, "R8 current page", 32'(rx_cur), 32'h37);
        check(mc_mask[63:56] === 8'h3f, "R8 mcast byte7", 32'(mc_mask[63:56]), 32'h3f);

        // R10 / R11 page 2
        wr(4'd0, 8'h82);
        rd(4'd3, 8'h00, "R10 page2 read");
        rd(4'd7, 8'h00, "R10 page2 status index");
        wr(4'd3, 8'h99);
        wr(4'd0, 8'h02);
        rd(4'd3, 8'h4c, "R11 page2 write ignored");
        rd(4'he, 8'h00, "R10 dcfg unreadable");

        // R12 hold
        repeat (2) @(negedge clk);
        check(rd_data === 8'h00, "R12 hold without strobe", 32'(rd_data), 0);
        check(exp_q.size() == 0, "R12 all reads seen", 32'(exp_q.size()), 0);
        done = 1;
        finish_run();
    end
endmodule